// File: doc/BRIEF.md
# Microcode Branch Sequencer

This unit steers the program counter of a microcoded vector engine. Each cycle that a 64-bit microinstruction is presented, the sequencer pulls the opcode, destination and immediate fields out of the word. It checks whether the opcode is a conditional jump, an unconditional jump, a return or an ordinary operation. It then writes the next 16-bit microcode address into its counter.

A conditional jump compares one 32-bit lane of two 96-bit operand rows as signed numbers. Two opcode bits pick the lane and three opcode bits pick the relation.

While idle, the unit waits for a start request that carries a routine entry address. The entry may be a fixed routine slot or a user routine with address bit 15 set. A return ends the routine: the busy flag drops, a one-cycle done pulse is produced, and the unit goes back to waiting.

Top module: `useq_branch_seq`

## Requirements
- R1: After reset, pc_o is 0, busy_o is 0 and done_o is 0.
- R2: While busy_o is 0, start_i loads entry_i into pc_o and sets busy_o on the next edge. Any 16-bit entry is accepted, including user entries with bit 15 set.
- R3: The instruction word is split into fields. Opcode is bits 63:48 and destination is bits 47:32. The immediate is bits 31:0, and its low 16 bits form the unconditional jump target.
- R4: A conditional jump opcode has bits 15:5 all zero, bits 4:3 nonzero and bits 2:0 below 6. Bits 4:3 select the lane of each row: 01 selects bits 31:0, 10 selects bits 63:32, and 11 selects bits 95:64.
- R5: Opcode bits 2:0 of a conditional jump give the relation of lane A to lane B, compared as signed: 000 greater, 001 less, 010 equal, 011 not equal, 100 greater-or-equal, 101 less-or-equal.
- R6: A taken conditional jump loads the destination field into pc_o. A jump that is not taken increments pc_o by one.
- R7: Opcodes with bits 2:0 equal to 110 or 111 inside the jump groups, and all other register-form operations, increment pc_o by one.
- R8: Opcode 0x0058 loads the low 16 bits of the immediate into pc_o. Any other opcode with bit 6 set increments pc_o by one.
- R9: Opcode 0x0000 (return) while busy clears busy_o, raises done_o for exactly one cycle, and leaves pc_o unchanged.
- R10: While busy_o is 1, a cycle with insn_valid_i low leaves pc_o unchanged, and start_i has no effect. This holds even in the cycle a return executes.
- R11: While busy_o is 0, instructions are ignored, so pc_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only while idle |
| entry_i | input | 16 | Routine entry address for a start |
| insn_valid_i | input | 1 | Microinstruction present this cycle |
| insn_i | input | 64 | Microinstruction word |
| row_a_i | input | 96 | First operand row, three 32-bit lanes |
| row_b_i | input | 96 | Second operand row, three 32-bit lanes |
| pc_o | output | 16 | Program counter |
| busy_o | output | 1 | Routine in progress |
| done_o | output | 1 | One-cycle pulse after a return |

## Verification
A start request and a return can land in the same cycle. The start must lose, because the unit is still busy at that edge. The bench provokes this by holding start_i high with a new entry while it issues the return. It expects busy_o low, done_o high and pc_o unchanged after that edge. On the following edge, with start_i still high, it expects the new entry in pc_o, busy_o set again and done_o cleared.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int INSN_W  = 64;
  localparam int FIELD_W = 16;
  localparam int ADDR_W  = 16;
  localparam int LANE_W  = 32;
  localparam int LANES   = 3;
  localparam int IMM_BIT = 6;

  localparam logic [FIELD_W-1:0] OP_RET  = 16'h0000;
  localparam logic [FIELD_W-1:0] OP_UJMP = 16'h0058;

  typedef enum logic [2:0] {
    CMP_GT = 3'd0,
    CMP_LT = 3'd1,
    CMP_EQ = 3'd2,
    CMP_NE = 3'd3,
    CMP_GE = 3'd4,
    CMP_LE = 3'd5
  } cmp_e;

  typedef struct packed {
    logic [FIELD_W-1:0] op;
    logic [FIELD_W-1:0] dst;
    logic [ADDR_W-1:0]  target;
    logic               is_ret;
    logic               is_ujmp;
    logic               is_cjmp;
    logic [1:0]         lane;
    logic [2:0]         rel;
  } dec_t;
endpackage

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
#(
  parameter int W = INSN_W
) (
  input  logic [W-1:0] insn_i,
  output dec_t         dec_o
);
  localparam int OP_LSB  = W - FIELD_W;
  localparam int DST_LSB = OP_LSB - FIELD_W;

  logic [FIELD_W-1:0] op;
  logic               imm_form;

  assign op       = insn_i[OP_LSB +: FIELD_W];
  assign imm_form = op[IMM_BIT];

  always_comb begin
    dec_o         = '0;
    dec_o.op      = op;
    dec_o.dst     = insn_i[DST_LSB +: FIELD_W];
    dec_o.target  = insn_i[ADDR_W-1:0];
    dec_o.is_ret  = (op == OP_RET);
    dec_o.is_ujmp = (op == OP_UJMP);
    // jump groups: upper bits clear, lane field nonzero, relation code 0..5
    dec_o.is_cjmp = !imm_form && (op[FIELD_W-1:5] == '0) &&
                    (op[4:3] != 2'b00) && (op[2:0] < 3'd6);
    dec_o.lane    = op[4:3];
    dec_o.rel     = op[2:0];
  end
endmodule

// File: rtl/useq_lane_cmp.sv
module useq_lane_cmp
  import useq_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES
) (
  input  logic [LW*NL-1:0] row_a_i,
  input  logic [LW*NL-1:0] row_b_i,
  input  logic [1:0]       lane_i,
  input  logic [2:0]       rel_i,
  output logic             hit_o
);
  logic [LW-1:0] a_l [NL];
  logic [LW-1:0] b_l [NL];
  logic [LW-1:0] a_s, b_s;
  logic          gt, lt, eq;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign a_l[g] = row_a_i[g*LW +: LW];
    assign b_l[g] = row_b_i[g*LW +: LW];
  end

  // lane code 1 picks lane 0
  always_comb begin
    a_s = '0;
    b_s = '0;
    for (int i = 0; i < NL; i++) begin
      if (lane_i == 2'(i + 1)) begin
        a_s = a_l[i];
        b_s = b_l[i];
      end
    end
  end

  assign gt = $signed(a_s) > $signed(b_s);
  assign lt = $signed(a_s) < $signed(b_s);
  assign eq = (a_s == b_s);

  always_comb begin
    unique case (rel_i)
      CMP_GT:  hit_o = gt;
      CMP_LT:  hit_o = lt;
      CMP_EQ:  hit_o = eq;
      CMP_NE:  hit_o = !eq;
      CMP_GE:  hit_o = gt || eq;
      CMP_LE:  hit_o = lt || eq;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_pc_reg.sv
module useq_pc_reg
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] entry_i,
  input  logic          exec_i,
  input  logic          ret_i,
  input  logic          ujmp_i,
  input  logic          cjmp_i,
  input  logic          hit_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [AW-1:0] pc_q;
  logic          busy_q, done_q;
  logic          accept;
  logic          step;

  assign accept = start_i && !busy_q;
  assign step   = exec_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pc_q   <= entry_i;
        busy_q <= 1'b1;
      end else if (step) begin
        if (ret_i) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (ujmp_i) begin
          pc_q <= target_i;
        end else if (cjmp_i && hit_i) begin
          pc_q <= dst_i;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end
  end

  assign pc_o   = pc_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/useq_branch_seq.sv
module useq_branch_seq
  import useq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     entry_i,
  input  logic                  insn_valid_i,
  input  logic [INSN_W-1:0]     insn_i,
  input  logic [LANE_W*LANES-1:0] row_a_i,
  input  logic [LANE_W*LANES-1:0] row_b_i,
  output logic [ADDR_W-1:0]     pc_o,
  output logic                  busy_o,
  output logic                  done_o
);
  dec_t dec;
  logic hit;

  useq_decode #(.W(INSN_W)) u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  useq_lane_cmp #(.LW(LANE_W), .NL(LANES)) u_cmp (
    .row_a_i (row_a_i),
    .row_b_i (row_b_i),
    .lane_i  (dec.lane),
    .rel_i   (dec.rel),
    .hit_o   (hit)
  );

  useq_pc_reg #(.AW(ADDR_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .entry_i  (entry_i),
    .exec_i   (insn_valid_i),
    .ret_i    (dec.is_ret),
    .ujmp_i   (dec.is_ujmp),
    .cjmp_i   (dec.is_cjmp),
    .hit_i    (hit),
    .dst_i    (dec.dst[ADDR_W-1:0]),
    .target_i (dec.target),
    .pc_o     (pc_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/useq_branch_seq_chk.sv
module useq_branch_seq_chk
  import useq_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [ADDR_W-1:0]       entry_i,
  input logic                    insn_valid_i,
  input logic [INSN_W-1:0]       insn_i,
  input logic [ADDR_W-1:0]       pc_o,
  input logic                    busy_o,
  input logic                    done_o
);
  logic [FIELD_W-1:0] op_c;
  assign op_c = insn_i[INSN_W-1 -: FIELD_W];

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && pc_o == $past(entry_i)));

  assert_ujmp_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && insn_valid_i && op_c == 16'h0058) |=> (pc_o == $past(insn_i[15:0])));

  assert_return_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && insn_valid_i && op_c == 16'h0000) |=> (!busy_o && done_o && $stable(pc_o)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_no_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !insn_valid_i) |=> (busy_o && $stable(pc_o)));

  assert_idle_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(pc_o)));
endmodule

bind useq_branch_seq useq_branch_seq_chk u_chk (.*);

// File: tb/useq_branch_seq_tb.sv
`timescale 1ns/1ps
module useq_branch_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] entry_i = '0;
  logic        insn_valid_i = 1'b0;
  logic [63:0] insn_i = '0;
  logic [95:0] row_a_i = '0;
  logic [95:0] row_b_i = '0;
  logic [15:0] pc_o;
  logic        busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_pc;

  always #2.5 clk_i = ~clk_i;

  useq_branch_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .entry_i(entry_i),
    .insn_valid_i(insn_valid_i), .insn_i(insn_i), .row_a_i(row_a_i),
    .row_b_i(row_b_i), .pc_o(pc_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_r(logic [15:0] op, logic [15:0] dst);
    return {op, dst, 16'h0000, 16'h0000};
  endfunction

  function automatic logic [63:0] mk_i(logic [15:0] op, logic [15:0] dst, logic [31:0] imm);
    return {op, dst, imm};
  endfunction

  // outputs settle 1 ns after the edge; inputs change there too
  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic exec(logic [63:0] w);
    insn_i = w;
    insn_valid_i = 1'b1;
    tick();
    insn_valid_i = 1'b0;
  endtask

  task automatic launch(logic [15:0] e);
    start_i = 1'b1;
    entry_i = e;
    tick();
    start_i = 1'b0;
    exp_pc = e;
  endtask

  task automatic t_reset();
    check("R1 pc", 32'(pc_o), 0);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 done", 32'(done_o), 0);
  endtask

  task automatic t_start();
    launch(16'd14);
    check("R2 pc", 32'(pc_o), 14);
    check("R2 busy", 32'(busy_o), 1);
  endtask

  task automatic t_plain();
    exec(mk_r(16'h0001, 16'h0777)); exp_pc++;
    check("R7 add pc", 32'(pc_o), 32'(exp_pc));
    exec(mk_r(16'h000E, 16'h0777)); exp_pc++;
    check("R7 code110 pc", 32'(pc_o), 32'(exp_pc));
    exec(mk_r(16'h0017, 16'h0777)); exp_pc++;
    check("R7 code111 pc", 32'(pc_o), 32'(exp_pc));
    exec(mk_r(16'h0028, 16'h0777)); exp_pc++;
    check("R7 bit5 op pc", 32'(pc_o), 32'(exp_pc));
  endtask

  task automatic t_jumps();
    logic signed [31:0] va [3];
    logic signed [31:0] vb [3];
    va[0] = -32'sd5; vb[0] = 32'sd3;
    va[1] = 32'sd7;  vb[1] = 32'sd7;
    va[2] = 32'sd3;  vb[2] = -32'sd5;
    for (int l = 1; l <= 3; l++) begin
      for (int c = 0; c < 6; c++) begin
        for (int p = 0; p < 3; p++) begin
          logic take;
          logic [15:0] dst;
          logic [15:0] op;
          case (c)
            0: take = va[p] >  vb[p];
            1: take = va[p] <  vb[p];
            2: take = va[p] == vb[p];
            3: take = va[p] != vb[p];
            4: take = va[p] >= vb[p];
            default: take = va[p] <= vb[p];
          endcase
          dst = 16'h0100 + 16'(l * 32 + c * 4 + p);
          op  = 16'((l << 3) | c);
          // selected lane gets the pair, other lanes get it swapped
          for (int k = 0; k < 3; k++) begin
            row_a_i[k*32 +: 32] = (k == l - 1) ? va[p] : vb[p];
            row_b_i[k*32 +: 32] = (k == l - 1) ? vb[p] : va[p];
          end
          exec(mk_r(op, dst));
          exp_pc = take ? dst : exp_pc + 1'b1;
          check($sformatf("R4 R5 R6 lane%0d rel%0d pair%0d", l, c, p), 32'(pc_o), 32'(exp_pc));
        end
      end
    end
  endtask

  task automatic t_imm();
    exec(mk_i(16'h0058, 16'h0999, 32'hABCD_1234)); exp_pc = 16'h1234;
    check("R3 R8 ujmp pc", 32'(pc_o), 32'h1234);
    exec(mk_i(16'h0048, 16'h0999, 32'h0000_0000)); exp_pc++;
    check("R8 imm-form jump bits pc", 32'(pc_o), 32'(exp_pc));
    exec(mk_i(16'h0040, 16'h0999, 32'h0000_5555)); exp_pc++;
    check("R8 setx pc", 32'(pc_o), 32'(exp_pc));
  endtask

  task automatic t_hold();
    start_i = 1'b1;
    entry_i = 16'h00D4;
    insn_i = mk_r(16'h0001, 16'h0);
    insn_valid_i = 1'b0;
    tick(); tick(); tick();
    start_i = 1'b0;
    check("R10 pc hold", 32'(pc_o), 32'(exp_pc));
    check("R10 busy hold", 32'(busy_o), 1);
  endtask

  task automatic t_return();
    exec(mk_r(16'h0000, 16'h0555));
    check("R9 busy", 32'(busy_o), 0);
    check("R9 done", 32'(done_o), 1);
    check("R9 pc", 32'(pc_o), 32'(exp_pc));
    exec(mk_i(16'h0058, 16'h0, 32'h0000_4242));
    check("R9 done pulse", 32'(done_o), 0);
    check("R11 idle pc", 32'(pc_o), 32'(exp_pc));
    check("R11 idle busy", 32'(busy_o), 0);
  endtask

  task automatic t_collide();
    launch(16'd33);
    check("R2 relaunch", 32'(pc_o), 33);
    start_i = 1'b1;
    entry_i = 16'd196;
    exec(mk_r(16'h0000, 16'h0));
    check("R10 collide busy", 32'(busy_o), 0);
    check("R10 collide done", 32'(done_o), 1);
    check("R10 collide pc", 32'(pc_o), 33);
    tick();
    start_i = 1'b0;
    check("R2 after collide pc", 32'(pc_o), 196);
    check("R2 after collide busy", 32'(busy_o), 1);
    check("R9 after collide done", 32'(done_o), 0);
    exp_pc = 16'd196;
    exec(mk_r(16'h0000, 16'h0));
  endtask

  task automatic t_user();
    launch(16'h8000);
    check("R2 user entry pc", 32'(pc_o), 32'h8000);
    exec(mk_r(16'h0006, 16'h0)); exp_pc++;
    check("R7 user step pc", 32'(pc_o), 32'h8001);
  endtask

  initial begin
    #1;
    t_reset();
    #6 rst_ni = 1'b1;
    tick();
    t_reset();
    t_start();
    t_plain();
    t_jumps();
    t_imm();
    t_hold();
    t_return();
    t_collide();
    t_user();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule